// File: doc/BRIEF.md
# Processor run control register unit

This unit sits beside a small embedded processor core and governs whether the core is fetching, halted, draining a long instruction, or held in a one-cycle reset. Software reaches it over a simple 32-bit register bus with a word index, a select, a write strobe and a combinational read-data return. Three words are mapped. Word 0 is the control word, which holds the core's start address, the enable, single-step, sleep and soft-reset bits, and a read-only run-state bit. Word 1 is a read-only status word that carries a one-cycle-delayed copy of the core's program counter. Word 2 is a 32-bit wakeup mask.

Toward the core, the unit drives a fetch enable, a one-cycle reset pulse and the program-counter value to load on leaving reset. From the core, it takes the live program counter, a flag that says a multi-cycle instruction is past its first cycle, a retire pulse, a sleep request and a 32-bit status vector. The wakeup mask is ANDed with the status vector and the result is OR-reduced to form the wakeup signal. That signal also clears the sleep indicator.

Top module: `proc_run_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_0001, the status word and the wakeup mask read 0, and fetch_en, run_state and core_rst are all low.
- R2: Control bits [31:16] hold a read/write start address, reset 0, that appears on rst_pc in the cycle after the write.
- R3: Writing 0 to control bit 0 (active-low soft reset) raises core_rst for exactly one cycle after the write edge. The bit reads 0 during that cycle and 1 afterwards with no further write. fetch_en is low during the pulse, and the unit's own fields keep their values.
- R4: Writing 1 to control bit 1 (enable) raises fetch_en one cycle after the write edge. The run-state bit (control bit 7 and output run_state) rises one cycle later.
- R5: Clearing enable while no multi-cycle instruction is in flight drops fetch_en at once and run_state on the following edge.
- R6: Clearing enable while core_multi_busy is high drops fetch_en at once, but run_state stays high for as long as core_multi_busy stays high. It falls on the first edge at which core_multi_busy is low.
- R7: Setting enable again after a halt resumes fetching without any core_rst pulse, and rst_pc is unchanged.
- R8: With control bit 2 (single-step) set, a core_retire pulse while enabled clears the enable bit, so fetch_en is low from the next cycle. Each further step needs another write. Without a retire, enable stays set.
- R9: Status word bits [15:0] show core_pc as sampled at the previous clock edge, and bits [31:16] read 0. Writes to the status word are ignored.
- R10: Word 2 is a read/write 32-bit wakeup mask, reset 0, that is driven on wake_mask. wakeup is high exactly when some bit is set both in the mask and in status_in.
- R11: Control bit 3 (sleep) stores written values and is set by core_sleep. It is cleared on the edge after wakeup is high, and wakeup takes priority over core_sleep. A bus write to the control word overrides both.
- R12: Control bits [15:8] and [6:4] read 0 and ignore writes, and the run-state bit ignores writes. Word index 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe (1 = write, 0 = read) |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| core_pc | input | 16 | Core's live program counter |
| core_multi_busy | input | 1 | A multi-cycle instruction is past its first cycle |
| core_retire | input | 1 | One instruction retired this cycle |
| core_sleep | input | 1 | Core requests sleep |
| status_in | input | 32 | Status inputs that may wake the core |
| fetch_en | output | 1 | Core may fetch new instructions |
| core_rst | output | 1 | One-cycle core reset pulse |
| rst_pc | output | 16 | Program counter loaded when the core leaves reset |
| run_state | output | 1 | Core is executing or draining |
| wakeup | output | 1 | Masked status OR-reduction |
| wake_mask | output | 32 | Current wakeup mask |

## Verification
The checker watches on every cycle the properties that tie outputs together. The reset pulse lasts one cycle and blocks fetching. run_state follows fetch_en one edge later. The run state falls at once when no long instruction is in flight and holds while one is draining. The status word mirrors the previous program counter. wakeup matches the masked status inputs. Other behaviours depend on bus writes landing on particular edges: the self-restoring reset bit, single-step clearing enable on retire, the sleep bit's set and clear priorities, reserved-bit masking, and the full walking-bit sweep of mask against status. Only the bench's directed scenarios can show these.

// File: rtl/prc_pkg.sv
package prc_pkg;
  // Register word indices on the bus.
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_WAKE = 2'd2,
    REG_NONE = 2'd3
  } reg_idx_e;

  // Control word bit layout.
  localparam int unsigned CB_SRST_N = 0;
  localparam int unsigned CB_EN     = 1;
  localparam int unsigned CB_STEP   = 2;
  localparam int unsigned CB_SLEEP  = 3;
  localparam int unsigned CB_RUN    = 7;
  localparam int unsigned CB_PC_LSB = 16;

  // Run sequencer states.
  typedef enum logic [1:0] {
    RS_HALTED   = 2'd0,
    RS_RUNNING  = 2'd1,
    RS_DRAINING = 2'd2
  } run_st_e;
endpackage

// File: rtl/prc_rst_sync.sv
module prc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/prc_wake_reduce.sv
module prc_wake_reduce #(
  parameter int unsigned STAT_W = 32,
  parameter int unsigned GRP_W  = 8
) (
  input  logic [STAT_W-1:0] mask,
  input  logic [STAT_W-1:0] stat,
  output logic              hit
);
  localparam int unsigned NGRP = (STAT_W + GRP_W - 1) / GRP_W;
  localparam int unsigned PADW = NGRP * GRP_W;

  logic [PADW-1:0] masked;
  logic [NGRP-1:0] grp_hit;

  always_comb begin
    masked = '0;
    masked[STAT_W-1:0] = mask & stat;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_hit[g] = |masked[g*GRP_W +: GRP_W];
  end

  assign hit = |grp_hit;
endmodule

// File: rtl/prc_run_fsm.sv
module prc_run_fsm
  import prc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic soft_rst_n,
  input  logic core_multi_busy,
  output logic fetch_en,
  output logic run_state,
  output logic core_rst
);
  run_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!soft_rst_n) begin
      st_d = RS_HALTED;
    end else if (enable) begin
      st_d = RS_RUNNING;
    end else if (st_q != RS_HALTED && core_multi_busy) begin
      st_d = RS_DRAINING;
    end else begin
      st_d = RS_HALTED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_HALTED;
    else        st_q <= st_d;
  end

  assign fetch_en  = enable & soft_rst_n;
  assign run_state = (st_q != RS_HALTED);
  assign core_rst  = ~soft_rst_n;
endmodule

// File: rtl/prc_regfile.sv
module prc_regfile
  import prc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PC_W   = 16,
  parameter int unsigned STAT_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PC_W-1:0]   core_pc,
  input  logic              core_retire,
  input  logic              core_sleep,
  input  logic              wake_hit,
  input  logic              run_state,
  output logic [PC_W-1:0]   start_pc,
  output logic              enable,
  output logic              soft_rst_n,
  output logic [STAT_W-1:0] wake_mask
);
  logic wr_ctrl, wr_wake, rd_act;
  logic [PC_W-1:0]   pc_q, pc_d, pcd_q;
  logic              en_q, en_d, step_q, step_d, slp_q, slp_d, srn_q, srn_d;
  logic [STAT_W-1:0] msk_q, msk_d;
  logic              pc_ce, en_ce, step_ce, slp_ce, msk_ce;

  assign wr_ctrl = bus_sel & bus_we & (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_wake = bus_sel & bus_we & (bus_addr == ADDR_W'(REG_WAKE));
  assign rd_act  = bus_sel & ~bus_we;

  // Next-state logic with explicit clock enables.
  always_comb begin
    pc_d    = bus_wdata[CB_PC_LSB +: PC_W];
    pc_ce   = wr_ctrl;
    step_d  = bus_wdata[CB_STEP];
    step_ce = wr_ctrl;
    msk_d   = bus_wdata[STAT_W-1:0];
    msk_ce  = wr_wake;
    // Active-low reset bit: takes a written 0 for one cycle, then restores.
    srn_d   = wr_ctrl ? bus_wdata[CB_SRST_N] : 1'b1;

    en_d  = en_q;
    en_ce = 1'b0;
    if (wr_ctrl) begin
      en_d  = bus_wdata[CB_EN];
      en_ce = 1'b1;
    end else if (step_q && en_q && core_retire) begin
      en_d  = 1'b0;
      en_ce = 1'b1;
    end

    slp_d  = slp_q;
    slp_ce = 1'b0;
    if (wr_ctrl) begin
      slp_d  = bus_wdata[CB_SLEEP];
      slp_ce = 1'b1;
    end else if (wake_hit) begin
      slp_d  = 1'b0;
      slp_ce = 1'b1;
    end else if (core_sleep) begin
      slp_d  = 1'b1;
      slp_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      en_q   <= 1'b0;
      step_q <= 1'b0;
      slp_q  <= 1'b0;
      srn_q  <= 1'b1;
      msk_q  <= '0;
      pcd_q  <= '0;
    end else begin
      if (pc_ce)   pc_q   <= pc_d;
      if (en_ce)   en_q   <= en_d;
      if (step_ce) step_q <= step_d;
      if (slp_ce)  slp_q  <= slp_d;
      if (msk_ce)  msk_q  <= msk_d;
      srn_q <= srn_d;
      pcd_q <= core_pc;
    end
  end

  // Read mux; reserved and unmapped bits return 0.
  always_comb begin
    bus_rdata = '0;
    if (rd_act) begin
      unique case (bus_addr)
        ADDR_W'(REG_CTRL): begin
          bus_rdata[CB_PC_LSB +: PC_W] = pc_q;
          bus_rdata[CB_RUN]            = run_state;
          bus_rdata[CB_SLEEP]          = slp_q;
          bus_rdata[CB_STEP]           = step_q;
          bus_rdata[CB_EN]             = en_q;
          bus_rdata[CB_SRST_N]         = srn_q;
        end
        ADDR_W'(REG_STAT): bus_rdata[PC_W-1:0]   = pcd_q;
        ADDR_W'(REG_WAKE): bus_rdata[STAT_W-1:0] = msk_q;
        default:           bus_rdata = '0;
      endcase
    end
  end

  assign start_pc   = pc_q;
  assign enable     = en_q;
  assign soft_rst_n = srn_q;
  assign wake_mask  = msk_q;
endmodule

// File: rtl/proc_run_ctrl.sv
module proc_run_ctrl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PC_W   = 16,
  parameter int unsigned STAT_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned GRP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PC_W-1:0]   core_pc,
  input  logic              core_multi_busy,
  input  logic              core_retire,
  input  logic              core_sleep,
  input  logic [STAT_W-1:0] status_in,
  output logic              fetch_en,
  output logic              core_rst,
  output logic [PC_W-1:0]   rst_pc,
  output logic              run_state,
  output logic              wakeup,
  output logic [STAT_W-1:0] wake_mask
);
  logic rst_sync_n;
  logic enable, soft_rst_n, wake_hit;

  prc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  prc_wake_reduce #(.STAT_W(STAT_W), .GRP_W(GRP_W)) u_wake (
    .mask(wake_mask), .stat(status_in), .hit(wake_hit)
  );

  prc_regfile #(
    .DATA_W(DATA_W), .PC_W(PC_W), .STAT_W(STAT_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_pc(core_pc), .core_retire(core_retire), .core_sleep(core_sleep),
    .wake_hit(wake_hit), .run_state(run_state),
    .start_pc(rst_pc), .enable(enable), .soft_rst_n(soft_rst_n),
    .wake_mask(wake_mask)
  );

  prc_run_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .enable(enable), .soft_rst_n(soft_rst_n),
    .core_multi_busy(core_multi_busy),
    .fetch_en(fetch_en), .run_state(run_state), .core_rst(core_rst)
  );

  assign wakeup = wake_hit;
endmodule

// File: rtl/proc_run_ctrl_chk.sv
module proc_run_ctrl_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PC_W   = 16,
  parameter int unsigned STAT_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PC_W-1:0]   core_pc,
  input logic              core_multi_busy,
  input logic [STAT_W-1:0] status_in,
  input logic              fetch_en,
  input logic              core_rst,
  input logic              run_state,
  input logic              wakeup,
  input logic [STAT_W-1:0] wake_mask
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  assert_rst_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !core_rst);

  assert_no_fetch_in_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> !fetch_en);

  assert_run_follows_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> run_state);

  assert_halt_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en && !core_multi_busy) |=> !run_state);

  assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state && !fetch_en && !core_rst && core_multi_busy) |=> run_state);

  assert_pc_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && bus_sel && !bus_we && bus_addr == ADDR_W'(1))
      |-> bus_rdata == {{(DATA_W-PC_W){1'b0}}, $past(core_pc)});

  assert_wake_reduce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup == ((wake_mask & status_in) != '0));
endmodule

bind proc_run_ctrl proc_run_ctrl_chk #(
  .DATA_W(DATA_W), .PC_W(PC_W), .STAT_W(STAT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .core_pc(core_pc),
  .core_multi_busy(core_multi_busy), .status_in(status_in),
  .fetch_en(fetch_en), .core_rst(core_rst), .run_state(run_state),
  .wakeup(wakeup), .wake_mask(wake_mask)
);

// File: tb/test_proc_run_ctrl.sv
module test_proc_run_ctrl;
  logic        clk, rst_n;
  logic        bus_sel, bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] core_pc;
  logic        core_multi_busy, core_retire, core_sleep;
  logic [31:0] status_in;
  logic        fetch_en, core_rst, run_state, wakeup;
  logic [15:0] rst_pc;
  logic [31:0] wake_mask;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  proc_run_ctrl i_proc_run_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_pc(core_pc), .core_multi_busy(core_multi_busy),
    .core_retire(core_retire), .core_sleep(core_sleep),
    .status_in(status_in),
    .fetch_en(fetch_en), .core_rst(core_rst), .rst_pc(rst_pc),
    .run_state(run_state), .wakeup(wakeup), .wake_mask(wake_mask)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    core_pc = 0; core_multi_busy = 0; core_retire = 0; core_sleep = 0; status_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    rd(2'd0, v); check("R1 ctrl", v, 32'h0000_0001);
    rd(2'd1, v); check("R1 status", v, 32'h0);
    rd(2'd2, v); check("R1 mask", v, 32'h0);
    check("R1 outs", {29'd0, fetch_en, run_state, core_rst}, 32'h0);

    // R2 start address
    wr(2'd0, 32'hABCD_0001);
    check("R2 rst_pc", {16'd0, rst_pc}, 32'h0000_ABCD);
    rd(2'd0, v); check("R2 ctrl", v, 32'hABCD_0001);

    // R3 soft reset pulse, fields kept
    wr(2'd0, 32'hABCD_0000);
    check("R3 pulse", {31'd0, core_rst}, 32'h1);
    rd(2'd0, v); check("R3 bit low", v, 32'hABCD_0000);
    @(negedge clk);
    check("R3 pulse end", {31'd0, core_rst}, 32'h0);
    rd(2'd0, v); check("R3 bit restored", v, 32'hABCD_0001);
    wr(2'd0, 32'h1234_0002);
    check("R3 rst with en", {30'd0, core_rst, fetch_en}, 32'h2);
    @(negedge clk);
    check("R3 fetch after", {30'd0, core_rst, fetch_en}, 32'h1);
    wr(2'd0, 32'h1234_0001);
    repeat (2) @(negedge clk);

    // R4 enable
    wr(2'd0, 32'h1234_0003);
    check("R4 fetch", {30'd0, fetch_en, run_state}, 32'h2);
    @(negedge clk);
    check("R4 run", {30'd0, fetch_en, run_state}, 32'h3);
    rd(2'd0, v); check("R4 run bit", v, 32'h1234_0083);

    // R5 immediate halt
    wr(2'd0, 32'h1234_0001);
    check("R5 fetch off", {30'd0, fetch_en, run_state}, 32'h1);
    @(negedge clk);
    check("R5 halted", {30'd0, fetch_en, run_state}, 32'h0);

    // R7 resume without reset
    for (int k = 0; k < 2; k++) begin
      wr(2'd0, 32'h1234_0003);
      check("R7 no rst", {30'd0, core_rst, fetch_en}, 32'h1);
      @(negedge clk);
      check("R7 resumed", {30'd0, core_rst, run_state}, 32'h1);
      check("R7 rst_pc", {16'd0, rst_pc}, 32'h0000_1234);
      if (k == 0) begin
        wr(2'd0, 32'h1234_0001);
        @(negedge clk);
      end
    end

    // R6 drain multi-cycle
    for (int hold = 1; hold <= 4; hold++) begin
      core_multi_busy = 1'b1;
      wr(2'd0, 32'h1234_0001);
      check("R6 fetch off", {31'd0, fetch_en}, 32'h0);
      for (int c = 0; c < hold; c++) begin
        @(negedge clk);
        check("R6 draining", {31'd0, run_state}, 32'h1);
      end
      core_multi_busy = 1'b0;
      @(negedge clk);
      check("R6 halted", {31'd0, run_state}, 32'h0);
      wr(2'd0, 32'h1234_0003);
      @(negedge clk);
    end

    // R8 single step
    for (int s = 0; s < 3; s++) begin
      wr(2'd0, 32'h1234_0007);
      repeat (2) @(negedge clk);
      check("R8 waits retire", {31'd0, fetch_en}, 32'h1);
      core_retire = 1'b1;
      @(negedge clk);
      core_retire = 1'b0;
      check("R8 stepped", {31'd0, fetch_en}, 32'h0);
      rd(2'd0, v); check("R8 en bit", {29'd0, v[2:0]}, 32'h5);
    end
    wr(2'd0, 32'h1234_0001);
    @(negedge clk);

    // R9 delayed program counter
    for (int p = 0; p < 16; p++) begin
      core_pc = 16'(p * 16'h1111 + 3);
      @(negedge clk);
      rd(2'd1, v); check("R9 pc", v, {16'd0, 16'(p * 16'h1111 + 3)});
      core_pc = 16'hFFFF;
      rd(2'd1, v); check("R9 delay", v, {16'd0, 16'(p * 16'h1111 + 3)});
    end
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check("R9 ro", v, 32'h0000_FFFF);

    // R10 walking mask against walking status
    for (int i = 0; i < 32; i++) begin
      wr(2'd2, 32'h1 << i);
      rd(2'd2, v); check("R10 mask rb", v, 32'h1 << i);
      check("R10 mask out", wake_mask, 32'h1 << i);
      for (int j = 0; j < 32; j++) begin
        status_in = 32'h1 << j;
        #1 check("R10 wakeup", {31'd0, wakeup}, {31'd0, i == j});
      end
      status_in = ~(32'h1 << i);
      #1 check("R10 inverse", {31'd0, wakeup}, 32'h0);
    end
    status_in = 0;

    // R11 sleep indicator
    wr(2'd2, 32'h0000_0020);
    wr(2'd0, 32'h0000_0009);
    repeat (2) @(negedge clk);
    rd(2'd0, v); check("R11 stored", {28'd0, v[3:0]}, 32'h9);
    status_in = 32'h0000_0020;
    @(negedge clk);
    rd(2'd0, v); check("R11 woken", {28'd0, v[3:0]}, 32'h1);
    status_in = 0;
    core_sleep = 1'b1;
    @(negedge clk);
    core_sleep = 1'b0;
    rd(2'd0, v); check("R11 core set", {28'd0, v[3:0]}, 32'h9);
    status_in = 32'h0000_0020;
    @(negedge clk);
    core_sleep = 1'b1;
    @(negedge clk);
    core_sleep = 1'b0;
    rd(2'd0, v); check("R11 wake priority", {28'd0, v[3:0]}, 32'h1);
    wr(2'd0, 32'h0000_0009);
    rd(2'd0, v); check("R11 write wins", {28'd0, v[3:0]}, 32'h9);
    status_in = 0;
    wr(2'd2, 32'h0);

    // R12 reserved and unmapped
    wr(2'd0, 32'h0000_FFF1);
    rd(2'd0, v); check("R12 reserved", v, 32'h0000_0001);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R12 unmapped", v, 32'h0);
    rd(2'd2, v); check("R12 mask kept", v, 32'h0);
    check("R12 outs", {29'd0, fetch_en, run_state, core_rst}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule